// File: doc/BRIEF.md
# Frame-Locked Clock Divider PLL

This block is an all-digital tracking loop that runs from a 7.68 MHz master clock. From that clock it derives three single-cycle enable strobes: a 1.536 MHz bit strobe, a 192 kHz line strobe and an 8 kHz frame strobe. It keeps the frame strobe phase-aligned to an external 8 kHz frame sync. Every output is a one-cycle enable in the master-clock domain and not a generated clock. Downstream logic uses the strobes to advance its own per-bit, per-line and per-frame state.

Tracking works on the first divider stage, which nominally counts five master cycles per bit. On each rising edge of the synchronised frame sync, a phase detector compares the edge with the local frame position and classifies it as early, late or aligned. An early result makes the next bit period one master cycle shorter. A late result makes it one master cycle longer. An aligned result leaves the dividers alone. Each correction therefore moves the local frame by one master period, and the loop settles once the sync lands inside a three-cycle window around the local frame boundary.

A lock flag reports whether the loop has settled. It rises after a run of aligned sync edges. It falls after a run of misaligned edges, or when the sync stops arriving.

Top module: `fl_frame_pll`

## Requirements
- R1: A synchronous active-high reset clears every counter and drives all strobes and the lock flag low. Counting begins after the last clock edge that sees reset high. The first bit strobe appears 5 cycles after that edge, the first line strobe 40 cycles after it, and the first frame strobe 960 cycles after it.
- R2: While no correction is pending, the bit strobe is high for exactly one cycle in every 5 master cycles.
- R3: The line strobe is high together with every 8th bit strobe. The frame strobe is high together with every 24th line strobe, which also coincides with a bit strobe. With no corrections, the frame strobe period is 960 cycles.
- R4: Frame sync passes through a two-flop synchroniser, and only its rising edges count. A rise first sampled at clock edge k is judged against the local frame position held after clock edge k+1. Position 0 is the cycle in which the frame strobe is high. Positions 0 and 1, and the last cycle of the preceding frame, count as aligned.
- R5: A misaligned edge that falls in the second half of the frame (line count 12 or more) is early. It makes the next bit period 4 cycles long, so the frame containing that bit lasts 959 cycles.
- R6: Any other misaligned edge is late. It makes the next bit period 6 cycles long, so the frame containing that bit lasts 961 cycles.
- R7: Each sync edge causes at most one step, and an aligned edge causes none. Frames therefore stay at 960 cycles while a 960-cycle sync is aligned, and change by exactly one cycle per misaligned edge.
- R8: The lock flag rises after 4 consecutive aligned edges. After only 3 it is still low.
- R9: The lock flag falls on the second consecutive misaligned edge. A single misaligned edge leaves it high.
- R10: If no sync edge arrives for 1100 master cycles, the lock flag falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 7.68 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync_i | input | 1 | External 8 kHz frame sync, asynchronous |
| bit_stb_o | output | 1 | One-cycle 1.536 MHz bit enable |
| line_stb_o | output | 1 | One-cycle 192 kHz line enable |
| frame_stb_o | output | 1 | One-cycle 8 kHz frame enable |
| locked_o | output | 1 | High while the local frame tracks the sync |

## Verification
Two functions can fall in the same cycle: a correction request coming out of the phase detector, and the prescaler closing a bit period. The request must still shape the very next bit. The bench provokes this by offsetting the sync so that edges land in the last cycles of a frame (offset -3, then -2 after one correction), where the verdict arrives during or just before the final prescaler cycle. It judges the result by the measured frame periods: exactly two 959-cycle frames, then steady 960-cycle frames with the lock regained. Late offsets of +3 and +5 check the stretching side in the same way, and offsets of -1, 0 and +1 confirm that the aligned window causes no step.

// File: rtl/fl_pll_pkg.sv
`timescale 1ns/1ps
package fl_pll_pkg;
  // verdict of one frame-sync comparison
  typedef enum logic [1:0] {
    PH_ALIGNED = 2'd0,
    PH_EARLY   = 2'd1,
    PH_LATE    = 2'd2
  } phase_e;
endpackage

// File: rtl/fl_sync_edge.sv
`timescale 1ns/1ps
module fl_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  // STAGES synchroniser flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/fl_mod_counter.sv
`timescale 1ns/1ps
module fl_mod_counter #(
  parameter int MOD = 8,
  parameter int W   = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] MAXV = W'(MOD - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (inc_i)   cnt_q <= (cnt_q == MAXV) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == MAXV);
endmodule

// File: rtl/fl_prescaler.sv
`timescale 1ns/1ps
module fl_prescaler #(
  parameter int DIV = 5,
  parameter int PW  = $clog2(DIV + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shorten_i,
  input  logic          stretch_i,
  output logic          tick_o,
  output logic [PW-1:0] pre_o
);
  localparam logic [PW-1:0] LAST_NOM   = PW'(DIV - 1);
  localparam logic [PW-1:0] LAST_SHORT = PW'(DIV - 2);
  localparam logic [PW-1:0] LAST_LONG  = PW'(DIV);

  logic [PW-1:0] pre_q, last_q;
  logic [1:0]    pend_q;   // {stretch, shorten}
  logic [1:0]    sel;

  assign tick_o = (pre_q == last_q);
  assign pre_o  = pre_q;

  // a held request wins; otherwise one arriving in the closing cycle is used
  always_comb sel = (pend_q != 2'b00) ? pend_q : {stretch_i, shorten_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      last_q <= LAST_NOM;
      pend_q <= 2'b00;
    end else if (tick_o) begin
      pre_q  <= '0;
      pend_q <= 2'b00;
      if (sel[0])      last_q <= LAST_SHORT;
      else if (sel[1]) last_q <= LAST_LONG;
      else             last_q <= LAST_NOM;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (pend_q == 2'b00) pend_q <= {stretch_i, shorten_i};
    end
  end

  AST_STEP_HELD: assert property (@(posedge clk) disable iff (rst)
    ((pend_q != 2'b00) && !tick_o) |=> (pend_q == $past(pend_q))); // R5
endmodule

// File: rtl/fl_phase_det.sv
`timescale 1ns/1ps
module fl_phase_det
  import fl_pll_pkg::*;
#(
  parameter int PW    = 3,
  parameter int BW    = 3,
  parameter int LW    = 5,
  parameter int LINES = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          tick_i,
  input  logic [PW-1:0] pre_i,
  input  logic [BW-1:0] bitn_i,
  input  logic          bitn_last_i,
  input  logic [LW-1:0] line_i,
  input  logic          line_last_i,
  output logic          vd_valid_o,
  output phase_e        vd_o
);
  localparam logic [LW-1:0] HALF = LW'(LINES / 2);

  logic   at_head, at_tail, upper;
  phase_e cls;

  assign at_head = (bitn_i == '0) && (line_i == '0) && (pre_i <= PW'(1));
  assign at_tail = bitn_last_i && line_last_i && tick_i;
  assign upper   = (line_i >= HALF);

  always_comb begin
    if (at_head || at_tail) cls = PH_ALIGNED;
    else if (upper)         cls = PH_EARLY;
    else                    cls = PH_LATE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vd_valid_o <= 1'b0;
      vd_o       <= PH_ALIGNED;
    end else begin
      vd_valid_o <= rise_i;
      if (rise_i) vd_o <= cls;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    vd_valid_o |=> !vd_valid_o); // R7
endmodule

// File: rtl/fl_lock_mon.sv
`timescale 1ns/1ps
module fl_lock_mon
  import fl_pll_pkg::*;
#(
  parameter int HITS    = 4,
  parameter int MISSES  = 2,
  parameter int TIMEOUT = 1100
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   vd_valid_i,
  input  phase_e vd_i,
  output logic   locked_o
);
  localparam int HW = $clog2(HITS + 1);
  localparam int MW = $clog2(MISSES + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [HW-1:0] HIT_TOP  = HW'(HITS - 1);
  localparam logic [MW-1:0] MISS_TOP = MW'(MISSES - 1);
  localparam logic [TW-1:0] TMO_TOP  = TW'(TIMEOUT - 1);

  logic [HW-1:0] hit_q;
  logic [MW-1:0] miss_q;
  logic [TW-1:0] tmo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q    <= '0;
      miss_q   <= '0;
      tmo_q    <= '0;
      locked_o <= 1'b0;
    end else if (vd_valid_i) begin
      tmo_q <= '0;
      if (vd_i == PH_ALIGNED) begin
        miss_q <= '0;
        if (hit_q >= HIT_TOP) locked_o <= 1'b1;
        else                  hit_q    <= hit_q + 1'b1;
      end else begin
        hit_q <= '0;
        if (miss_q >= MISS_TOP) locked_o <= 1'b0;
        else                    miss_q   <= miss_q + 1'b1;
      end
    end else if (tmo_q == TMO_TOP) begin
      locked_o <= 1'b0;
      hit_q    <= '0;
      miss_q   <= '0;
    end else begin
      tmo_q <= tmo_q + 1'b1;
    end
  end

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(vd_valid_i && (vd_i == PH_ALIGNED))); // R8
  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_o) |-> ($past(vd_valid_i && (vd_i != PH_ALIGNED)) ||
                         $past(!vd_valid_i && (tmo_q == TMO_TOP)))); // R9
endmodule

// File: rtl/fl_frame_pll.sv
`timescale 1ns/1ps
module fl_frame_pll
  import fl_pll_pkg::*;
#(
  parameter int MCLK_PER_BIT    = 5,
  parameter int BITS_PER_LINE   = 8,
  parameter int LINES_PER_FRAME = 24,
  parameter int SYNC_STAGES     = 2,
  parameter int LOCK_HITS       = 4,
  parameter int LOCK_MISSES     = 2,
  parameter int SYNC_TIMEOUT    = 1100
) (
  input  logic clk,
  input  logic rst,
  input  logic fsync_i,
  output logic bit_stb_o,
  output logic line_stb_o,
  output logic frame_stb_o,
  output logic locked_o
);
  localparam int PW = $clog2(MCLK_PER_BIT + 1);
  localparam int BW = (BITS_PER_LINE > 1) ? $clog2(BITS_PER_LINE) : 1;
  localparam int LW = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1;

  logic          fs_rise, tick;
  logic [PW-1:0] pre;
  logic [BW-1:0] bitn;
  logic [LW-1:0] line;
  logic          bitn_last, line_last, bit_wrap, frm_wrap;
  logic          vd_valid;
  phase_e        vd;

  fl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(fsync_i), .rise_o(fs_rise));

  fl_prescaler #(.DIV(MCLK_PER_BIT), .PW(PW)) u_pre (
    .clk(clk), .rst(rst),
    .shorten_i(vd_valid && (vd == PH_EARLY)),
    .stretch_i(vd_valid && (vd == PH_LATE)),
    .tick_o(tick), .pre_o(pre));

  fl_mod_counter #(.MOD(BITS_PER_LINE), .W(BW)) u_bitn (
    .clk(clk), .rst(rst), .inc_i(tick), .cnt_o(bitn), .at_max_o(bitn_last));

  assign bit_wrap = tick & bitn_last;

  fl_mod_counter #(.MOD(LINES_PER_FRAME), .W(LW)) u_line (
    .clk(clk), .rst(rst), .inc_i(bit_wrap), .cnt_o(line), .at_max_o(line_last));

  assign frm_wrap = bit_wrap & line_last;

  fl_phase_det #(.PW(PW), .BW(BW), .LW(LW), .LINES(LINES_PER_FRAME)) u_det (
    .clk(clk), .rst(rst), .rise_i(fs_rise), .tick_i(tick), .pre_i(pre),
    .bitn_i(bitn), .bitn_last_i(bitn_last), .line_i(line), .line_last_i(line_last),
    .vd_valid_o(vd_valid), .vd_o(vd));

  fl_lock_mon #(.HITS(LOCK_HITS), .MISSES(LOCK_MISSES), .TIMEOUT(SYNC_TIMEOUT)) u_lock (
    .clk(clk), .rst(rst), .vd_valid_i(vd_valid), .vd_i(vd), .locked_o(locked_o));

  // registered strobes: high in the first cycle of each new period
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_stb_o   <= 1'b0;
      line_stb_o  <= 1'b0;
      frame_stb_o <= 1'b0;
    end else begin
      bit_stb_o   <= tick;
      line_stb_o  <= bit_wrap;
      frame_stb_o <= frm_wrap;
    end
  end

  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_stb_o |=> !bit_stb_o); // R2
  AST_LINE_HAS_BIT: assert property (@(posedge clk) disable iff (rst)
    line_stb_o |-> bit_stb_o); // R3
  AST_FRAME_HAS_LINE: assert property (@(posedge clk) disable iff (rst)
    frame_stb_o |-> (line_stb_o && bit_stb_o)); // R3
endmodule

// File: tb/fl_frame_pll_tb_top.sv
`timescale 1ns/1ps
module fl_frame_pll_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fsync = 1'b0;
  logic bit_stb, line_stb, frame_stb, locked;

  always #2.5 clk = ~clk;

  fl_frame_pll dut_i (
    .clk(clk), .rst(rst), .fsync_i(fsync),
    .bit_stb_o(bit_stb), .line_stb_o(line_stb),
    .frame_stb_o(frame_stb), .locked_o(locked));

  // offset, expected steps, period of a stepped frame
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{ 0, 0, 960}, '{ 1, 0, 960}, '{-1, 0, 960},
    '{ 5, 4, 961}, '{-3, 2, 959}, '{ 3, 2, 961}};

  int cyc = 0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  int fr_t [256];
  int fr_n = 0;
  int bt [8];
  int bn = 0;
  int lt0 = -1;
  bit fs_en = 1'b0;
  int fs_next = -1, fs_off = -1, fs_last = -1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_stb) begin
        if (fr_n < 256) fr_t[fr_n] = cyc;
        fr_n++;
      end
      if (bit_stb && bn < 8) begin bt[bn] = cyc; bn++; end
      if (line_stb && lt0 < 0) lt0 = cyc;
    end
  end

  // periodic frame sync: raised after clock edge fs_next, held 20 cycles
  always @(negedge clk) begin
    if (fs_en && cyc == fs_next) begin
      fsync = 1'b1;
      fs_last = cyc;
      fs_off = cyc + 20;
      fs_next = fs_next + 960;
    end else if (cyc == fs_off) begin
      fsync = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // waits for a frame strobe; returns its cycle and the index of the next frame
  task automatic wait_frame(output int e, output int k);
    @(negedge clk);
    while (!frame_stb) @(negedge clk);
    e = cyc;
    @(negedge clk);
    k = fr_n;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int x, e, k, r;
    // reset state (R1)
    wait_cyc(5);
    chk("R1 outputs in reset", {28'd0, bit_stb, line_stb, frame_stb, locked}, 0);
    rst = 1'b0;
    x = cyc;
    fs_next = x + 958;
    fs_en = 1'b1;
    wait_cyc(x + 41);
    chk("R1 first bit strobe", bt[0], x + 5);
    chk("R2 second bit strobe", bt[1], x + 10);
    chk("R2 third bit strobe", bt[2], x + 15);
    chk("R3 first line strobe", lt0, x + 40);
    // acquisition with an aligned sync (R8)
    wait_cyc(x + 958 + 960 * 2 + 10);
    chk("R1 first frame strobe", fr_t[0], x + 960);
    chk("R8 no lock after 3 aligned", int'(locked), 0);
    wait_cyc(x + 958 + 960 * 3 + 10);
    chk("R8 lock after 4 aligned", int'(locked), 1);

    // table of sync offsets
    for (int v = 0; v < NV; v++) begin
      string tag;
      wait_frame(e, k);
      fs_next = e + 958 + VEC[v][0];
      while (fr_n < k + 9) @(negedge clk);
      if (VEC[v][1] == 0)      tag = "R4/R7 aligned window";
      else if (VEC[v][0] < 0)  tag = "R5 early step";
      else                     tag = "R6 late step";
      for (int j = 0; j < 8; j++)
        chk(tag, fr_t[k + j + 1] - fr_t[k + j], (j < VEC[v][1]) ? VEC[v][2] : 960);
      wait_cyc(cyc + 20);
      chk("R8 locked after settling", int'(locked), 1);
    end

    // two misaligned edges drop the lock (R9)
    wait_frame(e, k);
    fs_next = e + 958 + 8;
    r = e + 958 + 8;
    wait_cyc(r + 10);
    chk("R9 one miss keeps lock", int'(locked), 1);
    wait_cyc(r + 960 + 10);
    chk("R9 second miss drops lock", int'(locked), 0);
    // realign and regain lock (R8)
    wait_frame(e, k);
    fs_next = e + 958;
    r = e + 958;
    wait_cyc(r + 1920 + 10);
    chk("R8 relock needs 4 edges", int'(locked), 0);
    wait_cyc(r + 2880 + 10);
    chk("R8 relock after 4 edges", int'(locked), 1);

    // sync stops: lock drops after 1100 cycles (R10)
    wait_frame(e, k);
    fs_en = 1'b0;
    r = fs_last;
    wait_cyc(r + 1090);
    chk("R10 lock held before timeout", int'(locked), 1);
    wait_cyc(r + 1120);
    chk("R10 lock dropped at timeout", int'(locked), 0);

    // reset in the middle of a run (R1)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs in second reset", {28'd0, bit_stb, line_stb, frame_stb, locked}, 0);
    rst = 1'b0;
    x = cyc;
    k = fr_n;
    while (fr_n <= k) @(negedge clk);
    chk("R1 frame after second reset", fr_t[k], x + 960);

    finish_run();
  end
endmodule